// File: doc/BRIEF.md
# Interrupt Coalescing Credit Controller

This block holds interrupt state for a parameterized set of vectors (eight by default). Each vector keeps a signed count of pending work. A one-cycle pulse on a vector's event input adds one to its count. The host returns credits by writing the credit word, and that write subtracts the returned amount. The same write can also clear the vector's mask and restart its coalescing countdown.

A vector raises a one-cycle interrupt pulse when three things hold at once: its mask is clear, its count is above zero, and its countdown has reached zero. When it fires, the countdown reloads from its programmed start value and the mask takes the value held in the vector's mask-on-fire register. Software therefore chooses between auto-masking after every interrupt and leaving the vector open.

The countdown steps on a shared prescaler tick, which keeps interrupt bursts apart in time. Register access uses a 32-bit write strobe and a combinational read of the word at the current address.

Top module: `irq_coal_ctrl`

## Requirements
- R1: After reset every vector's mask reads 1, and its start value, count, mask-on-fire and countdown all read 0.
- R2: Each vector owns a 32-byte window starting at byte address vector*32. The word at byte offset 0 is the 6-bit countdown start value; writes keep bits 5:0 and the rest read as 0. Offset 4 is the mask, a single bit where 1 means masked. Offset 8 is the credit word. Offset 12 is the mask-on-fire bit. Offset 16 is the live countdown, which is read-only.
- R3: Each event pulse adds one to the vector's count. The count reads back in bits 15:0 of the credit word as a 16-bit two's complement value.
- R4: A write to the credit word subtracts its bits 14:0 from the count. Bits 16 and 17 of that word always read back as 0.
- R5: A credit-word write with bit 16 set clears the vector's mask.
- R6: A credit-word write with bit 17 set loads the countdown from the start value, and the countdown word reads that value just after the write.
- R7: The countdown drops by one on each prescaler tick (every TICK_DIV cycles) and holds at 0 once it gets there.
- R8: The interrupt output pulses in each cycle in which the mask is 0, the signed count is greater than 0 and the countdown is 0. With a start value of 0 and mask-on-fire at 0, it pulses in every cycle while the count stays positive.
- R9: When a vector fires, its countdown reloads from the start value and its mask takes the mask-on-fire value.
- R10: Offsets 20, 24 and 28 inside a window, and addresses of vectors at or beyond NUM_VEC, read as 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at reg_addr (combinational) |
| event_in | input | NUM_VEC | Per-vector one-cycle work event |
| irq_out | output | NUM_VEC | Per-vector one-cycle interrupt pulse |

## Verification
The temporal checks on mask reload, countdown reload, countdown stepping and count stability hold only in cycles with no register write, so they assume that a host write may override any automatic update. The bench never drives an event and a credit write to the same vector in the same cycle. It spaces each write one full clock apart from the next, and it reads the countdown right after the write that sets it, before any prescaler tick can land.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int WORD_W     = 32;
  localparam int COAL_W     = 6;
  localparam int CRED_W     = 16;
  localparam int CRED_MAG_W = 15;
  localparam int STRIDE_LG  = 5;
  localparam int UNMASK_BIT = 16;
  localparam int RESTART_BIT = 17;

  localparam logic [2:0] WD_START   = 3'd0;
  localparam logic [2:0] WD_MASK    = 3'd1;
  localparam logic [2:0] WD_CREDIT  = 3'd2;
  localparam logic [2:0] WD_MASKFIRE = 3'd3;
  localparam logic [2:0] WD_REMAIN  = 3'd4;

  function automatic logic [CRED_W-1:0] credit_step(
    input logic [CRED_W-1:0]     cur,
    input logic                  inc,
    input logic                  ret,
    input logic [CRED_MAG_W-1:0] mag);
    logic [CRED_W-1:0] sub;
    sub = ret ? {1'b0, mag} : '0;
    return cur + {{(CRED_W-1){1'b0}}, inc} - sub;
  endfunction

  function automatic logic credit_pending(input logic [CRED_W-1:0] c);
    return !c[CRED_W-1] && (c != '0);
  endfunction
endpackage

// File: rtl/irq_coal_tick.sv
module irq_coal_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CNT_W = $clog2(TICK_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
      logic [CNT_W-1:0] cnt_q;
      assign tick = (cnt_q == LAST);
      always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_coal_vector.sv
module irq_coal_vector
  import irq_coal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                event_i,
  input  logic                wr_en,
  input  logic [2:0]          word_sel,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rd_word,
  output logic                fire_o,
  output logic                mask_o,
  output logic                maskfire_o,
  output logic [CRED_W-1:0]   credit_o,
  output logic [COAL_W-1:0]   remain_o,
  output logic [COAL_W-1:0]   start_o
);
  logic [COAL_W-1:0] start_q, remain_q;
  logic              mask_q, maskfire_q;
  logic [CRED_W-1:0] credit_q;

  logic wr_start, wr_mask, wr_credit, wr_maskfire;
  logic do_unmask, do_restart, fire;

  always_comb begin
    wr_start    = wr_en && (word_sel == WD_START);
    wr_mask     = wr_en && (word_sel == WD_MASK);
    wr_credit   = wr_en && (word_sel == WD_CREDIT);
    wr_maskfire = wr_en && (word_sel == WD_MASKFIRE);
    do_unmask   = wr_credit && wdata[UNMASK_BIT];
    do_restart  = wr_credit && wdata[RESTART_BIT];
    fire        = !mask_q && credit_pending(credit_q) && (remain_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= '0;
      mask_q     <= 1'b1;
      maskfire_q <= 1'b0;
      credit_q   <= '0;
      remain_q   <= '0;
    end else begin
      if (wr_start)    start_q    <= wdata[COAL_W-1:0];
      if (wr_maskfire) maskfire_q <= wdata[0];
      credit_q <= credit_step(credit_q, event_i, wr_credit, wdata[CRED_MAG_W-1:0]);
      if (do_unmask)    mask_q <= 1'b0;
      else if (wr_mask) mask_q <= wdata[0];
      else if (fire)    mask_q <= maskfire_q;
      if (fire || do_restart)          remain_q <= start_q;
      else if (tick && remain_q != '0) remain_q <= remain_q - 1'b1;
    end
  end

  always_comb begin
    case (word_sel)
      WD_START:    rd_word = {{(WORD_W-COAL_W){1'b0}}, start_q};
      WD_MASK:     rd_word = {{(WORD_W-1){1'b0}}, mask_q};
      WD_CREDIT:   rd_word = {{(WORD_W-CRED_W){1'b0}}, credit_q};
      WD_MASKFIRE: rd_word = {{(WORD_W-1){1'b0}}, maskfire_q};
      WD_REMAIN:   rd_word = {{(WORD_W-COAL_W){1'b0}}, remain_q};
      default:     rd_word = '0;
    endcase
  end

  assign fire_o     = fire;
  assign mask_o     = mask_q;
  assign maskfire_o = maskfire_q;
  assign credit_o   = credit_q;
  assign remain_o   = remain_q;
  assign start_o    = start_q;
endmodule

// File: rtl/irq_coal_regif.sv
module irq_coal_regif
  import irq_coal_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 16
) (
  input  logic                           reg_wr_en,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [NUM_VEC-1:0][WORD_W-1:0] rd_bus,
  output logic [NUM_VEC-1:0]             vec_wr,
  output logic [2:0]                     word_sel,
  output logic [WORD_W-1:0]              reg_rdata
);
  localparam int IDX_W = ADDR_W - STRIDE_LG;

  logic [IDX_W-1:0]   vec_idx;
  logic [NUM_VEC-1:0] vec_hit;

  assign vec_idx  = reg_addr[ADDR_W-1:STRIDE_LG];
  assign word_sel = reg_addr[STRIDE_LG-1:2];

  always_comb begin
    reg_rdata = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      vec_hit[v] = (vec_idx == IDX_W'(v));
      vec_wr[v]  = reg_wr_en && vec_hit[v];
      if (vec_hit[v]) reg_rdata = reg_rdata | rd_bus[v];
    end
  end
endmodule

// File: rtl/irq_coal_ctrl.sv
module irq_coal_ctrl
  import irq_coal_pkg::*;
#(
  parameter int NUM_VEC  = 8,
  parameter int ADDR_W   = 16,
  parameter int TICK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] event_in,
  output logic [NUM_VEC-1:0] irq_out
);
  logic                           tick;
  logic [NUM_VEC-1:0]             vec_wr;
  logic [2:0]                     word_sel;
  logic [NUM_VEC-1:0][WORD_W-1:0] rd_bus;

  logic [NUM_VEC-1:0]             vec_fire;
  logic [NUM_VEC-1:0]             vec_mask;
  logic [NUM_VEC-1:0]             vec_maskfire;
  logic [NUM_VEC-1:0][CRED_W-1:0] vec_credit;
  logic [NUM_VEC-1:0][COAL_W-1:0] vec_remain;
  logic [NUM_VEC-1:0][COAL_W-1:0] vec_start;

  irq_coal_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  irq_coal_regif #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_regif (
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .rd_bus(rd_bus),
    .vec_wr(vec_wr), .word_sel(word_sel), .reg_rdata(reg_rdata));

  generate
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      irq_coal_vector u_vec (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .event_i(event_in[v]), .wr_en(vec_wr[v]), .word_sel(word_sel),
        .wdata(reg_wdata), .rd_word(rd_bus[v]),
        .fire_o(vec_fire[v]), .mask_o(vec_mask[v]),
        .maskfire_o(vec_maskfire[v]), .credit_o(vec_credit[v]),
        .remain_o(vec_remain[v]), .start_o(vec_start[v]));
    end
  endgenerate

  assign irq_out = vec_fire;
endmodule

// File: rtl/irq_coal_checker.sv
module irq_coal_checker #(
  parameter int NUM_VEC = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [NUM_VEC-1:0]       ev,
  input logic [NUM_VEC-1:0]       irq,
  input logic [NUM_VEC-1:0]       mask_q,
  input logic [NUM_VEC-1:0]       maskfire_q,
  input logic [NUM_VEC-1:0][15:0] credit_q,
  input logic [NUM_VEC-1:0][5:0]  remain_q,
  input logic [NUM_VEC-1:0][5:0]  start_q
);
  generate
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_chk
      // R9: firing loads the mask from mask-on-fire
      assert_fire_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[i] && !wr_en) |=> (mask_q[i] == $past(maskfire_q[i])));
      // R9: firing reloads the countdown
      assert_fire_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[i] && !wr_en) |=> (remain_q[i] == $past(start_q[i])));
      // R7: countdown steps down by at most one
      assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq[i] && !wr_en) |=> ((remain_q[i] == $past(remain_q[i])) ||
                                 (remain_q[i] == $past(remain_q[i]) - 6'd1)));
      // R7: countdown holds at zero
      assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq[i] && !wr_en && remain_q[i] == 6'd0) |=> (remain_q[i] == 6'd0));
      // R3: count only moves on an event or a write
      assert_credit_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ev[i]) |=> $stable(credit_q[i]));
      // R8: with auto-mask set, a pulse lasts one cycle
      assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[i] && maskfire_q[i] && !wr_en) |=> !irq[i]);
    end
  endgenerate
endmodule

bind irq_coal_ctrl irq_coal_checker #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .ev(event_in), .irq(irq_out),
  .mask_q(vec_mask), .maskfire_q(vec_maskfire), .credit_q(vec_credit),
  .remain_q(vec_remain), .start_q(vec_start));

// File: tb/irq_coal_ctrl_bench.sv
module irq_coal_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV  = 8;
  localparam int AW  = 16;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NV-1:0] event_in = '0;
  logic [NV-1:0] irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt [NV];

  irq_coal_ctrl #(.NUM_VEC(NV), .ADDR_W(AW), .TICK_DIV(DIV)) u_irq_coal_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .event_in(event_in), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < NV; i++) irq_cnt[i] = 0;
  always @(negedge clk)
    for (int i = 0; i < NV; i++) if (irq_out[i]) irq_cnt[i] = irq_cnt[i] + 1;

  function automatic logic [AW-1:0] adr(input int v, input int word);
    return AW'(v * 32 + word * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_now(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic pulse(input int v);
    @(negedge clk);
    event_in[v] = 1'b1;
    @(negedge clk);
    event_in = '0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int v = 0; v < NV; v += NV - 1) begin
      rd(adr(v, 0), d); check("R1 start", d, 32'h0);
      rd(adr(v, 1), d); check("R1 mask", d, 32'h1);
      rd(adr(v, 2), d); check("R1 credit", d, 32'h0);
      rd(adr(v, 3), d); check("R1 maskfire", d, 32'h0);
      rd(adr(v, 4), d); check("R1 remain", d, 32'h0);
    end
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(adr(0, 0), 32'hFF);       rd(adr(0, 0), d); check("R2 start width", d, 32'h3F);
    wr(adr(0, 1), 32'h2);        rd(adr(0, 1), d); check("R2 mask bit", d, 32'h0);
    wr(adr(0, 1), 32'h3);        rd(adr(0, 1), d); check("R2 mask set", d, 32'h1);
    wr(adr(5, 3), 32'h1);        rd(adr(5, 3), d); check("R2 stride maskfire", d, 32'h1);
    rd(adr(4, 3), d);            check("R2 neighbour untouched", d, 32'h0);
    wr(adr(5, 3), 32'h0);
    wr(adr(0, 0), 32'h0);
  endtask

  task automatic t_credits();
    logic [31:0] d;
    int base;
    base = irq_cnt[2];
    repeat (3) pulse(2);
    rd(adr(2, 2), d); check("R3 three events", d, 32'h3);
    wr(adr(2, 2), 32'h5);
    rd(adr(2, 2), d); check("R4 subtract to negative", d, 32'h0000FFFE);
    wr(adr(2, 2), 32'h0003_0000);
    rd(adr(2, 2), d); check("R4 flag bits read zero", d, 32'h0000FFFE);
    rd(adr(2, 1), d); check("R5 unmask", d, 32'h0);
    repeat (20) @(negedge clk);
    #2;
    check("R8 no fire on negative count", irq_cnt[2] - base, 0);
    pulse(2); pulse(2);
    rd(adr(2, 2), d); check("R3 count back to zero", d, 32'h0);
    repeat (5) @(negedge clk);
    #2;
    check("R8 no fire on zero count", irq_cnt[2] - base, 0);
  endtask

  task automatic t_fire_automask();
    logic [31:0] d;
    bit seen;
    wr(adr(1, 0), 32'h3);
    wr(adr(1, 3), 32'h1);
    wr(adr(1, 2), 32'h0002_0000);
    rd_now(adr(1, 4), d); check("R6 restart loads start", d, 32'h3);
    pulse(1);
    wr(adr(1, 2), 32'h0001_0000);
    seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      #1;
      if (irq_out[1]) seen = 1'b1;
    end
    check("R8 vector fires", 32'(seen), 32'h1);
    @(negedge clk);
    rd_now(adr(1, 4), d); check("R9 countdown reloaded", d, 32'h3);
    rd_now(adr(1, 1), d); check("R9 auto-masked", d, 32'h1);
    repeat (30) @(negedge clk);
    #2;
    check("R8 single pulse when masked", irq_cnt[1], 1);
    rd(adr(1, 2), d); check("R3 firing keeps count", d, 32'h1);
  endtask

  task automatic t_countdown();
    logic [31:0] d;
    wr(adr(3, 0), 32'h2);
    wr(adr(3, 2), 32'h0002_0000);
    rd_now(adr(3, 4), d); check("R6 restart value", d, 32'h2);
    repeat (2 * DIV + 2) @(negedge clk);
    rd_now(adr(3, 4), d); check("R7 reaches zero", d, 32'h0);
    repeat (3 * DIV) @(negedge clk);
    rd_now(adr(3, 4), d); check("R7 holds at zero", d, 32'h0);
  endtask

  task automatic t_stream();
    int snap;
    pulse(4);
    wr(adr(4, 2), 32'h0001_0000);
    #2; snap = irq_cnt[4];
    repeat (5) @(negedge clk);
    #2; check("R8 pulse every cycle", irq_cnt[4] - snap, 5);
    wr(adr(4, 2), 32'h1);
    #2; snap = irq_cnt[4];
    repeat (5) @(negedge clk);
    #2; check("R8 stops after credit return", irq_cnt[4] - snap, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(adr(0, 5), 32'hFFFF_FFFF);
    rd(adr(0, 5), d); check("R10 reserved reads zero", d, 32'h0);
    wr(adr(0, 7), 32'h0003_0005);
    rd(adr(0, 2), d); check("R10 reserved write no effect", d, 32'h0);
    wr(adr(NV, 2), 32'h0001_0005);
    rd(adr(NV, 2), d); check("R10 out-of-range reads zero", d, 32'h0);
    rd(adr(0, 2), d); check("R10 no alias credit", d, 32'h0);
    rd(adr(0, 1), d); check("R10 no alias mask", d, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_credits();
    t_fire_automask();
    t_countdown();
    t_stream();
    t_reserved();
    repeat (4) @(negedge clk);
    report();
  end
endmodule